// File: doc/BRIEF.md
# MSI Termination and Status Aggregator

This block is the landing point for message-signalled interrupts. A posted write on a simple memory-mapped port names a vector in two parts. The address selects one of 128 termination registers, arranged as 16 groups of 8 registers each. The write data selects one of the 16 bits inside that register. The block sets that bit and holds it until software reads the register.

For each group the block keeps a summary word with one bit per termination register. A summary bit is set while its register holds any pending bit. The block drives 16 level interrupt lines, one per group. An interrupt handler polls the summary word of its group, then reads the termination registers that the summary marks. Each such read returns the pending bits and clears them.

The block covers 2048 vectors in total. A logical vector v maps to group v mod 16, termination register v / 256 inside that group, and write data (v / 16) mod 16.

Top module: `msi_term_agg`

## Requirements
- R1: After a synchronous reset every termination register is zero, every irqOut line is low and rdData is zero.
- R2: A write with data d in 0..15 to byte offset (n << 19) + (x << 16), with n in 0..15 and x in 0..7, sets bit d of termination register x of group n. Bits from earlier writes stay set.
- R3: A read of a termination register returns its pending bits on rdData[15:0] one cycle after rdEn, and clears that register at the same clock edge.
- R4: A read at offset 0x800000 + (n << 16) returns group n's summary one cycle after rdEn. Bit x is 1 exactly when termination register x of group n is non-zero, and bits 15:8 are zero. This read changes no state.
- R5: irqOut[n] is a registered level. It is high one cycle after any termination register of group n holds a pending bit, and low one cycle after all of them are clear.
- R6: When a write and a read address the same termination register in one cycle, the read returns the bits held before that edge, and the bit from the write remains pending afterwards.
- R7: These writes are ignored: a write whose data is above 15, a write to a summary offset, and a write to an offset whose bits 15:0 are not zero.
- R8: A write built from logical vector v through the mapping above sets a bit that no other vector uses, and this bit is read back at that mapped register and position.
- R9: A read of any offset that is neither a termination register nor a summary register returns zero and clears nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Posted write strobe |
| wrAddr | input | 24 | Write byte offset from the block base |
| wrData | input | 32 | Write data; the bit number inside the register |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 24 | Read byte offset from the block base |
| rdData | output | 16 | Read result, valid the cycle after rdEn |
| irqOut | output | 16 | Level interrupt, one line per group |

## Verification
The hardest case to reach from the ports is a new message that arrives in the same cycle as the read-to-clear of the register it targets. If the design gets this wrong, the message is lost without any sign. The bench first leaves one bit pending. It then drives wrEn and rdEn together on the same register address, each carrying a different bit. It checks that the read returns only the older bit, and that a second read finds the newer bit still pending. The vector mapping is tested with vectors at both ends of the space and in the middle. The bench checks that the expected set of interrupt lines rises before it drains each register.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  localparam int GROUPS      = 16;
  localparam int IDX_PER_GRP = 8;
  localparam int VEC_PER_IDX = 16;
  localparam int GRP_W = $clog2(GROUPS);
  localparam int IDX_W = $clog2(IDX_PER_GRP);
  localparam int BIT_W = $clog2(VEC_PER_IDX);

  // Strobes from the decoder to the register bank
  typedef struct packed {
    logic                   setHit;
    logic [GRP_W-1:0]       setGrp;
    logic [IDX_W-1:0]       setIdx;
    logic [VEC_PER_IDX-1:0] setMask;
    logic                   clrHit;
    logic [GRP_W-1:0]       clrGrp;
    logic [IDX_W-1:0]       clrIdx;
    logic                   sumHit;
    logic [GRP_W-1:0]       sumGrp;
    logic                   rdAny;
  } strobe_t;
endpackage

// File: rtl/msi_term_ctrl.sv
module msi_term_ctrl
  import msi_term_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int STRIDE_LSB = 16
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           strb
);
  localparam int IDX_LSB     = STRIDE_LSB;
  localparam int GRP_LSB     = STRIDE_LSB + IDX_W;
  localparam int TOP_BIT     = ADDR_W - 1;
  localparam int SUM_PAD_LSB = STRIDE_LSB + GRP_W;

  // Termination space: top bit clear, register-aligned offset
  function automatic logic isTerm(input logic [ADDR_W-1:0] a);
    return !a[TOP_BIT] && (a[STRIDE_LSB-1:0] == '0);
  endfunction

  // Summary space: top bit set, no bits between group field and top bit
  function automatic logic isSum(input logic [ADDR_W-1:0] a);
    return a[TOP_BIT] && (a[STRIDE_LSB-1:0] == '0) &&
           (a[TOP_BIT-1:SUM_PAD_LSB] == '0);
  endfunction

  logic dataOk;
  assign dataOk = (wrData[DATA_W-1:BIT_W] == '0);

  always_comb begin
    strb         = '0;
    strb.setHit  = wrEn && isTerm(wrAddr) && dataOk;
    strb.setGrp  = wrAddr[GRP_LSB +: GRP_W];
    strb.setIdx  = wrAddr[IDX_LSB +: IDX_W];
    strb.setMask = {{(VEC_PER_IDX-1){1'b0}}, 1'b1} << wrData[BIT_W-1:0];
    strb.clrHit  = rdEn && isTerm(rdAddr);
    strb.clrGrp  = rdAddr[GRP_LSB +: GRP_W];
    strb.clrIdx  = rdAddr[IDX_LSB +: IDX_W];
    strb.sumHit  = rdEn && isSum(rdAddr);
    strb.sumGrp  = rdAddr[STRIDE_LSB +: GRP_W];
    strb.rdAny   = rdEn;
  end
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                strb,
  output logic [VEC_PER_IDX-1:0] rdData,
  output logic [GROUPS-1:0]      irqOut
);
  logic [VEC_PER_IDX-1:0] pend    [GROUPS][IDX_PER_GRP];
  logic [VEC_PER_IDX-1:0] pendNxt [GROUPS][IDX_PER_GRP];
  logic [IDX_PER_GRP-1:0] sumBits [GROUPS];
  logic [GROUPS-1:0]      anyPend;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar x = 0; x < IDX_PER_GRP; x++) begin : g_idx
      logic setSel, clrSel;
      assign setSel = strb.setHit && (strb.setGrp == GRP_W'(g)) &&
                      (strb.setIdx == IDX_W'(x));
      assign clrSel = strb.clrHit && (strb.clrGrp == GRP_W'(g)) &&
                      (strb.clrIdx == IDX_W'(x));
      // A set in the clearing cycle survives the clear
      assign pendNxt[g][x] = (clrSel ? '0 : pend[g][x]) |
                             (setSel ? strb.setMask : '0);
      assign sumBits[g][x] = |pend[g][x];
    end
    assign anyPend[g] = |sumBits[g];
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '{default: '0};
    else     pend <= pendNxt;
  end

  always_ff @(posedge clk) begin
    if (rst) irqOut <= '0;
    else     irqOut <= anyPend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdAny) begin
      if (strb.clrHit)      rdData <= pend[strb.clrGrp][strb.clrIdx];
      else if (strb.sumHit) rdData <= VEC_PER_IDX'(sumBits[strb.sumGrp]);
      else                  rdData <= '0;
    end
  end
endmodule

// File: rtl/msi_term_agg.sv
module msi_term_agg
  import msi_term_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int STRIDE_LSB = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [VEC_PER_IDX-1:0] rdData,
  output logic [GROUPS-1:0]      irqOut
);
  strobe_t strb;

  msi_term_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRIDE_LSB(STRIDE_LSB)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  msi_term_bank u_bank (
    .clk(clk), .rst(rst), .strb(strb), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/msi_term_agg_sva.sv
module msi_term_agg_sva
  import msi_term_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int STRIDE_LSB = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wrEn,
  input logic [DATA_W-1:0]      wrData,
  input logic                   rdEn,
  input logic [ADDR_W-1:0]      rdAddr,
  input logic [VEC_PER_IDX-1:0] rdData,
  input logic [GROUPS-1:0]      irqOut
);
  // A line can only rise two edges after a write was presented
  p_irq_rise_needs_write_r5: assert property (@(posedge clk) disable iff (rst)
    (|(irqOut & ~$past(irqOut))) |-> $past(wrEn, 2));

  // A line can only fall two edges after a read was presented
  p_irq_fall_needs_read_r3: assert property (@(posedge clk) disable iff (rst)
    (|(~irqOut & $past(irqOut))) |-> $past(rdEn, 2));

  // Out-of-range data with no read leaves the lines unchanged
  p_bad_data_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrData[DATA_W-1:BIT_W] != '0) && !rdEn) |=> ##1 $stable(irqOut));

  // Upper half of the read word is zero in the summary space
  p_sum_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr[ADDR_W-1]) |=> (rdData[VEC_PER_IDX-1:IDX_PER_GRP] == '0));

  // Offsets off a register boundary read as zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rdEn && (rdAddr[STRIDE_LSB-1:0] != '0)) |=> (rdData == '0));
endmodule

bind msi_term_agg msi_term_agg_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRIDE_LSB(STRIDE_LSB)
) u_sva (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
  .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
);

// File: tb/msi_term_agg_test.sv
module msi_term_agg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [23:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [23:0] rdAddr = '0;
  logic [15:0] rdData;
  logic [15:0] irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  msi_term_agg uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [23:0] termAddr(input int g, input int x);
    return 24'((g << 19) + (x << 16));
  endfunction

  function automatic logic [23:0] sumAddr(input int g);
    return 24'(32'h800000 + (g << 16));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [23:0] a, output logic [15:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", 32'(irqOut), 0);
    chk("R1 rdData after reset", 32'(rdData), 0);
    doRead(termAddr(3, 5), d);
    chk("R1 register empty after reset", 32'(d), 0);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    doWrite(termAddr(3, 5), 2);
    doWrite(termAddr(3, 5), 11);
    idle();
    chk("R5 irq raised for group 3", 32'(irqOut), 32'h0008);
    doRead(sumAddr(3), d);
    chk("R4 summary group 3", 32'(d), 32'h0020);
    doRead(sumAddr(3), d);
    chk("R4 summary read has no side effect", 32'(d), 32'h0020);
    doRead(termAddr(3, 5), d);
    chk("R2 accumulated bits", 32'(d), 32'h0804);
    doRead(termAddr(3, 5), d);
    chk("R3 cleared by read", 32'(d), 0);
    chk("R5 irq dropped after clear", 32'(irqOut), 0);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    doWrite(termAddr(2, 1), 3);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = termAddr(2, 1); wrData = 9;
    rdEn = 1'b1; rdAddr = termAddr(2, 1);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R6 read returns old bits", 32'(rdData), 32'h0008);
    doRead(termAddr(2, 1), d);
    chk("R6 colliding bit survives", 32'(d), 32'h0200);
  endtask

  task automatic t_ignored();
    logic [15:0] d;
    doWrite(termAddr(0, 0), 16);
    doWrite(termAddr(0, 0), 32'h8000_0001);
    doWrite(sumAddr(0), 1);
    doWrite(24'h000004, 1);
    idle();
    chk("R7 no irq from ignored writes", 32'(irqOut), 0);
    doRead(sumAddr(0), d);
    chk("R7 summary still zero", 32'(d), 0);
    doRead(termAddr(0, 0), d);
    chk("R7 register still zero", 32'(d), 0);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    doWrite(termAddr(1, 0), 0);
    doRead(24'h010004, d);
    chk("R9 misaligned read is zero", 32'(d), 0);
    doRead(24'h900000, d);
    chk("R9 gap above summary reads zero", 32'(d), 0);
    doRead(termAddr(1, 0), d);
    chk("R9 unmapped reads cleared nothing", 32'(d), 32'h0001);
  endtask

  task automatic t_mapping();
    int vecs [5] = '{0, 255, 256, 2047, 1000};
    logic [15:0] d;
    foreach (vecs[i]) begin
      int v = vecs[i];
      doWrite(24'(((8 * (v % 16)) + (v / 256)) << 16), 32'((v / 16) % 16));
    end
    idle();
    chk("R8 groups raised by mapped vectors", 32'(irqOut), 32'h8101);
    foreach (vecs[i]) begin
      int v = vecs[i];
      doRead(termAddr(v % 16, v / 256), d);
      chk($sformatf("R8 vector %0d", v), 32'(d), 32'(1 << ((v / 16) % 16)));
    end
    idle();
    chk("R5 all lines low after drain", 32'(irqOut), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_collision();
    t_ignored();
    t_unmapped();
    t_mapping();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule